// File: doc/BRIEF.md
# T1 Bit-Serial Elastic Store

This block carries a serial T1 bit stream from the line-side write clock into the system-side read clock. Each accepted write bit lands in a bit-wide circular store, and the system side takes bits back out in the same order. A two-bit size code sets how many bits may be outstanding: one frame (193 bits), two frames (386 bits), a short 96-bit window, or no storage at all. In bypass the input bit goes straight to the output. When the read side runs dry or the write side runs too far ahead, the block signals a slip and restarts the read position half the current depth behind the most recent write. Software-free recentering is also possible through a request pin, but only while the slot-mapping function is switched off.

Both stream edges use valid/ready naming, with no back-pressure in either direction. The line side cannot be stalled, so `wr_valid` is a bit strobe with no ready. On the system side `rd_ready` is the system's read strobe. A bit is taken whenever `rd_ready` is high and `rd_valid` is high. A strobe while `rd_valid` is low is not held off. It counts as an underflow and causes a slip. `rd_data` always shows the next bit before it is read.

Top module: `t1_elastic_store`

## Requirements
- R1: With `size_sel` = 2'b00 (bypass), `rd_data` equals `wr_data` and `rd_valid` equals `wr_valid` in the same cycle. No slip occurs while the code stays at 00.
- R2: Codes 2'b01, 2'b10 and 2'b11 give depths of 193, 386 and 96 bits. With writes stopped, a recenter leaves exactly floor(depth/2) bits (96, 193, 48) readable before `rd_valid` falls.
- R3: On every slip the read position is set floor(depth/2) bits behind the synchronized write count. After a recenter with writes stopped, the next bit delivered is write number W−floor(depth/2), where W is the total number of bits written.
- R4: A change of `size_sel` to a non-bypass code causes one slip pulse and a recenter at the new depth.
- R5: In a non-bypass mode, `rd_ready` high while `rd_valid` is low (underflow) gives a one-cycle `slip_pulse` on the next `rd_clk` edge, followed by a recenter.
- R6: When the synchronized occupancy exceeds the current depth (overflow), a slip pulse and a recenter follow on the next `rd_clk` edge.
- R7: A rising edge of `recenter_req` while `slot_map_off` is high forces a slip and a recenter. The request passes a two-flop synchronizer, so `slip_pulse` is high in the cycle after the third `rd_clk` edge that sees the request. The request must stay high for at least two read-clock periods.
- R8: While `slot_map_off` is low, `recenter_req` has no effect. No slip occurs and the buffered bits are delivered unchanged.
- R9: When several slip causes fall in the same cycle (for example a recenter edge and an underflow), only one single-cycle slip pulse and one recenter occur.
- R10: Without slips, bits leave in the order they were written, with none lost or repeated.
- R11: During reset `slip_pulse` is low and the store is empty.
- R12: The write count crosses into the read domain as a Gray code that changes by at most one bit per write-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Line-side bit clock |
| rd_clk | input | 1 | System-side bit clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| size_sel | input | 2 | Depth code: 00 bypass, 01 193 bits, 10 386 bits, 11 96 bits (read domain) |
| slot_map_off | input | 1 | High when slot mapping is disabled; enables recenter requests |
| recenter_req | input | 1 | Rising edge requests a forced recenter |
| wr_valid | input | 1 | Write strobe: one line bit this cycle |
| wr_data | input | 1 | Line bit |
| rd_ready | input | 1 | System read strobe |
| rd_valid | output | 1 | A buffered bit is available (or `wr_valid` in bypass) |
| rd_data | output | 1 | Next bit for the system (show-ahead) |
| slip_pulse | output | 1 | One-cycle slip indication in the read domain |

## Verification
A forced recenter from the request pin and an underflow from the system strobe can be detected in the same read cycle. Both resolve to the same pointer move. The bench drains the store empty and raises the request. It then asserts `rd_ready` exactly in the cycle where the synchronized edge is seen, so both causes fire at the same edge. The result is judged by counting `slip_pulse` cycles over the window (exactly one) and by confirming that the following drain starts at write W−depth/2 and yields exactly depth/2 bits, which shows one recenter rather than two.

// File: rtl/t1es_pkg.sv
package t1es_pkg;

  typedef enum logic [1:0] {
    SZ_BYPASS    = 2'b00,
    SZ_ONE_FRAME = 2'b01,
    SZ_TWO_FRAME = 2'b10,
    SZ_SHORT     = 2'b11
  } es_size_e;

  // Usable depth in bits for a size code; bypass holds nothing.
  function automatic int unsigned size_depth(input logic [1:0] code,
                                             input int unsigned frame_bits,
                                             input int unsigned short_bits);
    case (code)
      SZ_ONE_FRAME: return frame_bits;
      SZ_TWO_FRAME: return 2 * frame_bits;
      SZ_SHORT:     return short_bits;
      default:      return 0;
    endcase
  endfunction

endpackage

// File: rtl/es_wr_side.sv
// Write-domain bit counter with a registered Gray copy for crossing.
module es_wr_side #(
  parameter int CW = 10,
  localparam int AW = CW - 1
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic [AW-1:0] waddr,
  output logic [CW-1:0] wgray
);
  logic [CW-1:0] wcnt;
  logic [CW-1:0] wcnt_nxt;

  assign wcnt_nxt = wcnt + CW'(1);
  assign waddr    = wcnt[AW-1:0];

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt  <= '0;
      wgray <= '0;
    end else if (wr_valid) begin
      wcnt  <= wcnt_nxt;
      wgray <= wcnt_nxt ^ (wcnt_nxt >> 1);
    end
  end
endmodule

// File: rtl/es_gray_sync.sv
// Two-flop synchronizer for a Gray count, converted back to binary.
module es_gray_sync #(
  parameter int CW = 10
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [CW-1:0] gray_in,
  output logic [CW-1:0] bin_out
);
  logic [CW-1:0] meta_q;
  logic [CW-1:0] sync_q;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_out[CW-1] = sync_q[CW-1];
    for (int i = CW - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ sync_q[i];
    end
  end
endmodule

// File: rtl/es_bitmem.sv
// Bit-wide circular store: written in the line domain, read combinationally.
module es_bitmem #(
  parameter int AW = 9,
  localparam int NBITS = 1 << AW
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  logic [NBITS-1:0] store_q;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (we) begin
      store_q[waddr] <= wdata;
    end
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/es_rd_ctrl.sv
// Read-domain pointer, occupancy, slip detection and recentering.
module es_rd_ctrl
  import t1es_pkg::*;
#(
  parameter int CW         = 10,
  parameter int FRAME_BITS = 193,
  parameter int SHORT_BITS = 96,
  localparam int AW = CW - 1
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [1:0]    size_sel,
  input  logic [CW-1:0] wsync,
  input  logic          rd_ready,
  input  logic          recenter_req,
  input  logic          slot_map_off,
  output logic [AW-1:0] raddr,
  output logic          buf_valid,
  output logic          slip_pulse,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] depth_cur
);
  logic [CW-1:0] rcnt;
  logic [CW-1:0] half_depth;
  logic [1:0]    size_q;
  logic          req_meta, req_sync, req_prev;
  logic          bypass;
  logic          under_hit, over_hit, size_hit, req_hit, recenter;

  assign depth_cur  = CW'(size_depth(size_sel, FRAME_BITS, SHORT_BITS));
  assign half_depth = depth_cur >> 1;
  assign bypass     = (size_sel == SZ_BYPASS);
  assign occ        = wsync - rcnt;
  assign buf_valid  = !bypass && (occ != '0);
  assign raddr      = rcnt[AW-1:0];

  // Slip causes; any one of them gives the same single recenter.
  assign under_hit = !bypass && rd_ready && (occ == '0);
  assign over_hit  = !bypass && (occ > depth_cur);
  assign size_hit  = !bypass && (size_sel != size_q);
  assign req_hit   = !bypass && slot_map_off && req_sync && !req_prev;
  assign recenter  = under_hit || over_hit || size_hit || req_hit;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_meta <= 1'b0;
      req_sync <= 1'b0;
      req_prev <= 1'b0;
      size_q   <= SZ_BYPASS;
    end else begin
      req_meta <= recenter_req;
      req_sync <= req_meta;
      req_prev <= req_sync;
      size_q   <= size_sel;
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt       <= '0;
      slip_pulse <= 1'b0;
    end else begin
      slip_pulse <= recenter;
      if (bypass) begin
        rcnt <= wsync;
      end else if (recenter) begin
        rcnt <= wsync - half_depth;
      end else if (rd_ready && (occ != '0)) begin
        rcnt <= rcnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/t1_elastic_store.sv
module t1_elastic_store
  import t1es_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int SHORT_BITS = 96,
  parameter int SYNC_SLACK = 8,
  localparam int MAX_DEPTH = 2 * FRAME_BITS,
  localparam int AW        = $clog2(MAX_DEPTH + SYNC_SLACK),
  localparam int CW        = AW + 1
) (
  input  logic       wr_clk,
  input  logic       rd_clk,
  input  logic       rst_n,
  input  logic [1:0] size_sel,
  input  logic       slot_map_off,
  input  logic       recenter_req,
  input  logic       wr_valid,
  input  logic       wr_data,
  input  logic       rd_ready,
  output logic       rd_valid,
  output logic       rd_data,
  output logic       slip_pulse
);
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] wgray, wsync, occ, depth_cur;
  logic          mem_bit, buf_valid, bypass;

  assign bypass = (size_sel == SZ_BYPASS);

  es_wr_side #(.CW(CW)) u_wr (
    .wr_clk (wr_clk), .rst_n (rst_n), .wr_valid (wr_valid),
    .waddr  (waddr),  .wgray (wgray)
  );

  es_gray_sync #(.CW(CW)) u_sync (
    .rd_clk (rd_clk), .rst_n (rst_n), .gray_in (wgray), .bin_out (wsync)
  );

  es_bitmem #(.AW(AW)) u_mem (
    .wr_clk (wr_clk), .rst_n (rst_n), .we (wr_valid), .waddr (waddr),
    .wdata  (wr_data), .raddr (raddr), .rdata (mem_bit)
  );

  es_rd_ctrl #(.CW(CW), .FRAME_BITS(FRAME_BITS), .SHORT_BITS(SHORT_BITS)) u_rd (
    .rd_clk       (rd_clk),       .rst_n        (rst_n),
    .size_sel     (size_sel),     .wsync        (wsync),
    .rd_ready     (rd_ready),     .recenter_req (recenter_req),
    .slot_map_off (slot_map_off), .raddr        (raddr),
    .buf_valid    (buf_valid),    .slip_pulse   (slip_pulse),
    .occ          (occ),          .depth_cur    (depth_cur)
  );

  assign rd_data  = bypass ? wr_data  : mem_bit;
  assign rd_valid = bypass ? wr_valid : buf_valid;
endmodule

// File: rtl/t1es_checker.sv
module t1es_checker #(
  parameter int CW = 10
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic [1:0]    size_sel,
  input logic          rd_ready,
  input logic          slip_pulse,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] depth_cur,
  input logic [CW-1:0] wgray
);
  AST_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray))); // R12

  AST_BYPASS_QUIET: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (size_sel == 2'b00 && $past(size_sel) == 2'b00) |=> !slip_pulse); // R1

  AST_UNDERFLOW_SLIP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (size_sel != 2'b00 && rd_ready && occ == '0) |=> slip_pulse); // R5

  AST_OVERFLOW_SLIP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (size_sel != 2'b00 && occ > depth_cur) |=> slip_pulse); // R6

  AST_RECENTER_BOUND: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (slip_pulse && $stable(size_sel)) |-> occ <= depth_cur); // R3
endmodule

bind t1_elastic_store t1es_checker #(.CW(CW)) u_t1es_checker (
  .wr_clk     (wr_clk),
  .rd_clk     (rd_clk),
  .rst_n      (rst_n),
  .size_sel   (size_sel),
  .rd_ready   (rd_ready),
  .slip_pulse (slip_pulse),
  .occ        (occ),
  .depth_cur  (depth_cur),
  .wgray      (wgray)
);

// File: tb/t1_elastic_store_bench.sv
module t1_elastic_store_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [1:0] size_sel;
  logic       slot_map_off, recenter_req, wr_valid, wr_data, rd_ready;
  logic       rd_valid, rd_data, slip_pulse;

  int n_chk = 0, n_fail = 0, slip_cnt = 0, w_total = 0;

  t1_elastic_store u_t1_elastic_store (
    .wr_clk (clk), .rd_clk (clk), .rst_n (rst_n), .size_sel (size_sel),
    .slot_map_off (slot_map_off), .recenter_req (recenter_req),
    .wr_valid (wr_valid), .wr_data (wr_data), .rd_ready (rd_ready),
    .rd_valid (rd_valid), .rd_data (rd_data), .slip_pulse (slip_pulse)
  );

  always @(negedge clk) if (rst_n && slip_pulse) slip_cnt++;

  function automatic logic pat(int i);
    int v = i ^ (i >> 2) ^ (i >> 5) ^ ((i * 3) >> 4);
    return v[0];
  endfunction

  function automatic int depth_of(int c);
    case (c)
      1: return 193;
      2: return 386;
      3: return 96;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_bits(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = pat(w_total);
      w_total++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Read while valid; compare against pattern from base; check the count.
  task automatic drain(string req, int base, int exp_n);
    int n = 0;
    forever begin
      @(negedge clk);
      if (!rd_valid || n > 600) begin
        rd_ready = 1'b0;
        break;
      end
      chk(req, rd_data, pat(base + n));
      rd_ready = 1'b1;
      n++;
    end
    chk({req, " count"}, n, exp_n);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s0, d, h;
    rst_n = 1'b0; size_sel = 2'b00; slot_map_off = 1'b0; recenter_req = 1'b0;
    wr_valid = 1'b0; wr_data = 1'b0; rd_ready = 1'b0;
    idle(3);
    chk("R11 slip in reset", slip_pulse, 0);
    chk("R11 valid in reset", rd_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R1: bypass passes the input through in the same cycle
    s0 = slip_cnt;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      wr_valid = k[1]; wr_data = k[0];
      #1;
      chk("R1 bypass data", rd_data, k[0]);
      chk("R1 bypass valid", rd_valid, k[1]);
    end
    @(negedge clk); wr_valid = 1'b0;
    idle(3);
    chk("R1 bypass no slip", slip_cnt - s0, 0);

    for (int c = 1; c <= 3; c++) begin
      d = depth_of(c); h = d / 2;
      write_bits(400);
      idle(5);
      // R4: size change recenters once
      s0 = slip_cnt;
      @(negedge clk); size_sel = 2'(c);
      idle(4);
      chk("R4 size change slip", slip_cnt - s0, 1);
      drain("R2 R3 R10 drain after size change", w_total - h, h);

      // R5: underflow strobe with empty store
      s0 = slip_cnt;
      @(negedge clk); rd_ready = 1'b1;
      @(negedge clk); rd_ready = 1'b0;
      chk("R5 underflow slip", slip_pulse, 1);
      idle(3);
      chk("R5 single pulse", slip_cnt - s0, 1);
      chk("R3 first bit after underflow", rd_data, pat(w_total - h));

      // R6: overflow from writes only
      s0 = slip_cnt;
      write_bits(d - h + 1);
      idle(5);
      chk("R6 overflow slip", slip_cnt - s0, 1);
      drain("R6 R3 drain after overflow", w_total - h, h);

      // R7: enabled recenter request
      slot_map_off = 1'b1;
      s0 = slip_cnt;
      @(negedge clk); recenter_req = 1'b1;
      idle(3);
      chk("R7 recenter latency", slip_pulse, 1);
      recenter_req = 1'b0;
      idle(3);
      chk("R7 recenter slip count", slip_cnt - s0, 1);
      drain("R7 R3 drain after recenter", w_total - h, h);

      // R8: request ignored while slot mapping is on
      slot_map_off = 1'b0;
      write_bits(10);
      idle(4);
      s0 = slip_cnt;
      @(negedge clk); recenter_req = 1'b1;
      idle(3); recenter_req = 1'b0;
      idle(3);
      chk("R8 ignored request no slip", slip_cnt - s0, 0);
      drain("R8 R10 data kept", w_total - 10, 10);

      // R9: recenter edge and underflow in the same cycle
      slot_map_off = 1'b1;
      s0 = slip_cnt;
      @(negedge clk); recenter_req = 1'b1;
      @(negedge clk);
      @(negedge clk); rd_ready = 1'b1;
      @(negedge clk); rd_ready = 1'b0;
      chk("R9 coincident slip", slip_pulse, 1);
      idle(2); recenter_req = 1'b0;
      idle(3);
      chk("R9 one pulse", slip_cnt - s0, 1);
      drain("R9 single recenter drain", w_total - h, h);
      slot_map_off = 1'b0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule